// File: doc/BRIEF.md
# Video Refresh Address Generator

This block produces the video memory address for a character-based CRT display controller. It keeps a running character address (MA) that steps once for each displayed character. It also keeps a line-start buffer (MA') that supplies the reload value at the start of each raster line. The horizontal character count, the raster-in-row count and the character-row count come from external timing counters. The frame, row and line events come in as strobes, all qualified by the character clock enable.

The reload and capture rules depend on a controller-variant select. Variants 0, 3 and 4 load both registers from the start address when a frame begins. Variant 1 also reloads MA from the start address on every raster line of character row 0. Variant 2 never loads MA from the start address directly. It refills MA' with the start address at the end of the frame's last displayed row. The memory address is built from the page bits, the raster bits and the 10-bit offset of MA. Bits 11:10 of MA are kept in the counter but are not driven out. Setting both of them lets an increment carry into the page bits, which gives a 32K screen.

Top module: `video_addr_gen`

## Requirements
- R1: While rst_ni is low, ma_o and addr_o are 0, and the line-start buffer is 0.
- R2: On a character-enable cycle with line_start_i and frame_start_i both high, any variant code other than 2 loads both MA and MA' from start_addr_i. Codes 5 to 7 behave as variant 0.
- R3: On any other character-enable cycle with line_start_i high, MA loads from MA'. The variant-1 row-0 case in R8 is the exception.
- R4: On a character-enable cycle without line_start_i, MA increments by one when hcc_i < disp_width_i and holds otherwise. With char_ce_i low, MA holds.
- R5: On a character-enable cycle without line_start_i, MA' captures the current MA when hcc_i equals disp_width_i and vlc_i equals max_raster_i. Outside these cases MA' holds, except at R2 and R7.
- R6: Variant 2 (variant_i = 3'd2): at a frame start, MA loads from MA' and MA' is left unchanged.
- R7: Variant 2: at the R5 capture point with last_row_i high, MA' takes start_addr_i instead of MA.
- R8: Variant 1 (variant_i = 3'd1): at every line start that is not a frame start and has vcc_i = 0, MA loads from start_addr_i.
- R9: On variants other than 1, a change to start_addr_i after the frame start has no effect on MA until the next frame start.
- R10: MA is a 14-bit binary counter. Its page bits 13:12 change on an increment only when bits 11:0 are all ones, so a carry reaches the page only with bits 11:10 both set. 3FFF wraps to 0000.
- R11: addr_o (15 bits) = {MA[13:12], vlc_i[2:0], MA[9:0]}. MA bits 11:10 do not appear in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_ce_i | input | 1 | Character clock enable; qualifies every event |
| line_start_i | input | 1 | Raster line start strobe |
| frame_start_i | input | 1 | First raster line of the frame (valid with line_start_i) |
| last_row_i | input | 1 | Current character row is the last displayed one |
| hcc_i | input | 8 | Horizontal character count |
| vlc_i | input | 5 | Raster count within the character row |
| vcc_i | input | 7 | Character row count |
| start_addr_i | input | 14 | Start address: offset 9:0, buffer size 11:10, page 13:12 |
| disp_width_i | input | 8 | Displayed characters per line |
| max_raster_i | input | 5 | Last raster index of a character row |
| variant_i | input | 3 | Controller variant select |
| ma_o | output | 14 | Running character address MA |
| addr_o | output | 15 | Mapped video memory word address |

## Verification
Every variant code, including an unused one, is driven through several three-row frames. Each frame changes the start address during the second raster of row 0. Variant 1 picks the change up at once, while the others hold it back until the next frame start. Variant 2 shows its own frame-start source and end-of-frame refill. The start addresses include an offset that wraps within its 1K buffer, a value with bits 11:10 set that carries into the next page, and 3FFx, which wraps to zero. This separates the 16K and 32K buffer modes. Cycles with the character enable low and cycles past the displayed width are mixed in to show that MA holds.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [2:0] {
    VAR_0 = 3'd0,
    VAR_1 = 3'd1,
    VAR_2 = 3'd2,
    VAR_3 = 3'd3,
    VAR_4 = 3'd4
  } variant_e;

  typedef enum logic [1:0] {
    MA_HOLD  = 2'd0,
    MA_INC   = 2'd1,
    MA_START = 2'd2,
    MA_BUF   = 2'd3
  } ma_src_e;

  typedef enum logic [1:0] {
    BUF_HOLD  = 2'd0,
    BUF_MA    = 2'd1,
    BUF_START = 2'd2
  } buf_src_e;
endpackage

// File: rtl/vag_ctrl.sv
module vag_ctrl
  import vag_pkg::*;
#(
  parameter int HCC_W = 8,
  parameter int VLC_W = 5,
  parameter int VCC_W = 7
) (
  input  logic             char_ce_i,
  input  logic             line_start_i,
  input  logic             frame_start_i,
  input  logic             last_row_i,
  input  logic [HCC_W-1:0] hcc_i,
  input  logic [VLC_W-1:0] vlc_i,
  input  logic [VCC_W-1:0] vcc_i,
  input  logic [HCC_W-1:0] disp_width_i,
  input  logic [VLC_W-1:0] max_raster_i,
  input  logic [2:0]       variant_i,
  output ma_src_e          ma_src_o,
  output buf_src_e         buf_src_o
);
  logic is_v1, is_v2, row_end, in_disp;

  assign is_v1   = (variant_i == VAR_1);
  assign is_v2   = (variant_i == VAR_2);
  assign row_end = (hcc_i == disp_width_i) && (vlc_i == max_raster_i);
  assign in_disp = (hcc_i < disp_width_i);

  always_comb begin
    ma_src_o  = MA_HOLD;
    buf_src_o = BUF_HOLD;
    if (char_ce_i) begin
      if (line_start_i) begin
        if (frame_start_i) begin
          if (is_v2) begin
            ma_src_o = MA_BUF;
          end else begin
            ma_src_o  = MA_START;
            buf_src_o = BUF_START;
          end
        end else if (is_v1 && (vcc_i == '0)) begin
          ma_src_o = MA_START;
        end else begin
          ma_src_o = MA_BUF;
        end
      end else begin
        if (in_disp) ma_src_o = MA_INC;
        // variant 2 refills the buffer from the start address at frame end
        if (row_end) buf_src_o = (is_v2 && last_row_i) ? BUF_START : BUF_MA;
      end
    end
  end
endmodule

// File: rtl/vag_ma_reg.sv
module vag_ma_reg
  import vag_pkg::*;
#(
  parameter int MA_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ma_src_e         ma_src_i,
  input  logic [MA_W-1:0] start_i,
  input  logic [MA_W-1:0] buf_i,
  output logic [MA_W-1:0] ma_o
);
  localparam int LOW_W = MA_W - 2;

  logic [MA_W-1:0] ma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ma_q <= '0;
    end else begin
      unique case (ma_src_i)
        MA_INC:   ma_q <= ma_q + 1'b1;
        MA_START: ma_q <= start_i;
        MA_BUF:   ma_q <= buf_i;
        default:  ma_q <= ma_q;
      endcase
    end
  end

  assign ma_o = ma_q;

  // R4
  ma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ma_src_i == MA_HOLD) |-> $stable(ma_q));

  // R10
  page_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ma_src_i == MA_INC) && ($past(ma_q[LOW_W-1:0]) != {LOW_W{1'b1}}))
      |-> (ma_q[MA_W-1:LOW_W] == $past(ma_q[MA_W-1:LOW_W])));
endmodule

// File: rtl/vag_line_buf.sv
module vag_line_buf
  import vag_pkg::*;
#(
  parameter int MA_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  buf_src_e        buf_src_i,
  input  logic [MA_W-1:0] ma_i,
  input  logic [MA_W-1:0] start_i,
  output logic [MA_W-1:0] buf_o
);
  logic [MA_W-1:0] buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
    end else begin
      unique case (buf_src_i)
        BUF_MA:    buf_q <= ma_i;
        BUF_START: buf_q <= start_i;
        default:   buf_q <= buf_q;
      endcase
    end
  end

  assign buf_o = buf_q;

  // R5
  buf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(buf_src_i == BUF_HOLD) |-> $stable(buf_q));
endmodule

// File: rtl/vag_addr_map.sv
module vag_addr_map #(
  parameter int PAGE_W  = 2,
  parameter int OFS_W   = 10,
  parameter int RA_BITS = 3,
  localparam int ADDR_W = PAGE_W + RA_BITS + OFS_W
) (
  input  logic [PAGE_W-1:0]  page_i,
  input  logic [RA_BITS-1:0] ra_i,
  input  logic [OFS_W-1:0]   ofs_i,
  output logic [ADDR_W-1:0]  addr_o
);
  assign addr_o = {page_i, ra_i, ofs_i};
endmodule

// File: rtl/video_addr_gen.sv
module video_addr_gen
  import vag_pkg::*;
#(
  parameter int MA_W    = 14,
  parameter int OFS_W   = 10,
  parameter int RA_BITS = 3,
  parameter int HCC_W   = 8,
  parameter int VLC_W   = 5,
  parameter int VCC_W   = 7,
  localparam int PAGE_W = 2,
  localparam int ADDR_W = PAGE_W + RA_BITS + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_ce_i,
  input  logic              line_start_i,
  input  logic              frame_start_i,
  input  logic              last_row_i,
  input  logic [HCC_W-1:0]  hcc_i,
  input  logic [VLC_W-1:0]  vlc_i,
  input  logic [VCC_W-1:0]  vcc_i,
  input  logic [MA_W-1:0]   start_addr_i,
  input  logic [HCC_W-1:0]  disp_width_i,
  input  logic [VLC_W-1:0]  max_raster_i,
  input  logic [2:0]        variant_i,
  output logic [MA_W-1:0]   ma_o,
  output logic [ADDR_W-1:0] addr_o
);
  ma_src_e         ma_src;
  buf_src_e        buf_src;
  logic [MA_W-1:0] ma, line_buf;

  vag_ctrl #(.HCC_W(HCC_W), .VLC_W(VLC_W), .VCC_W(VCC_W)) ctrl_i (
    .char_ce_i    (char_ce_i),
    .line_start_i (line_start_i),
    .frame_start_i(frame_start_i),
    .last_row_i   (last_row_i),
    .hcc_i        (hcc_i),
    .vlc_i        (vlc_i),
    .vcc_i        (vcc_i),
    .disp_width_i (disp_width_i),
    .max_raster_i (max_raster_i),
    .variant_i    (variant_i),
    .ma_src_o     (ma_src),
    .buf_src_o    (buf_src)
  );

  vag_ma_reg #(.MA_W(MA_W)) ma_reg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ma_src_i(ma_src),
    .start_i (start_addr_i),
    .buf_i   (line_buf),
    .ma_o    (ma)
  );

  vag_line_buf #(.MA_W(MA_W)) line_buf_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .buf_src_i(buf_src),
    .ma_i     (ma),
    .start_i  (start_addr_i),
    .buf_o    (line_buf)
  );

  vag_addr_map #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .RA_BITS(RA_BITS)) addr_map_i (
    .page_i(ma[MA_W-1:MA_W-PAGE_W]),
    .ra_i  (vlc_i[RA_BITS-1:0]),
    .ofs_i (ma[OFS_W-1:0]),
    .addr_o(addr_o)
  );

  assign ma_o = ma;

  // R2
  frame_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(char_ce_i && line_start_i && frame_start_i && (variant_i != 3'd2))
      |-> (ma_o == $past(start_addr_i)));

  // R6
  v2_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(char_ce_i && line_start_i && frame_start_i && (variant_i == 3'd2))
      |-> (ma_o == $past(line_buf)));

  // R8
  v1_row0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(char_ce_i && line_start_i && !frame_start_i && (variant_i == 3'd1) && (vcc_i == '0))
      |-> (ma_o == $past(start_addr_i)));
endmodule

// File: tb/video_addr_gen_tb_top.sv
module video_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce, ls, fs, last;
  logic [7:0]  hcc, r1;
  logic [4:0]  vlc, r9;
  logic [6:0]  vcc;
  logic [13:0] sa;
  logic [2:0]  var_sel;
  logic [13:0] ma_o;
  logic [14:0] addr_o;

  int checks = 0;
  int errors = 0;
  logic [13:0] m_ma = '0;
  logic [13:0] m_buf = '0;

  always #2.5 clk = ~clk;

  video_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .char_ce_i(ce), .line_start_i(ls),
    .frame_start_i(fs), .last_row_i(last), .hcc_i(hcc), .vlc_i(vlc),
    .vcc_i(vcc), .start_addr_i(sa), .disp_width_i(r1), .max_raster_i(r9),
    .variant_i(var_sel), .ma_o(ma_o), .addr_o(addr_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] map_addr(logic [13:0] m, logic [4:0] ra);
    return {m[13:12], ra[2:0], m[9:0]};
  endfunction

  task automatic step(bit s_ls, bit s_fs, bit s_ce, int h, int ra, int row, bit s_last, string ovr);
    string tag;
    @(negedge clk);
    ls = s_ls; fs = s_fs; ce = s_ce; last = s_last;
    hcc = h[7:0]; vlc = ra[4:0]; vcc = row[6:0];
    tag = "R4";
    if (s_ce) begin
      if (s_ls) begin
        if (s_fs) begin
          if (var_sel == 3'd2) begin m_ma = m_buf; tag = "R6"; end
          else begin m_ma = sa; m_buf = sa; tag = "R2"; end
        end else if (var_sel == 3'd1 && row == 0) begin
          m_ma = sa; tag = "R8";
        end else begin
          m_ma = m_buf; tag = "R3";
        end
      end else begin
        if (h == int'(r1) && ra == int'(r9)) begin
          if (var_sel == 3'd2 && s_last) begin m_buf = sa; tag = "R7"; end
          else begin m_buf = m_ma; tag = "R5"; end
        end
        if (h < int'(r1)) begin
          if (m_ma[9:0] == 10'h3FF) tag = "R10";
          m_ma = m_ma + 14'd1;
        end
      end
    end
    if (ovr != "") tag = ovr;
    @(posedge clk);
    #1;
    chk(tag, 32'(ma_o), 32'(m_ma));
    chk("R11", 32'(addr_o), 32'(map_addr(m_ma, vlc)));
  endtask

  task automatic run_frame(logic [13:0] sa_frame, logic [13:0] sa_mid);
    int rows = 3;
    sa = sa_frame;
    for (int row = 0; row < rows; row++) begin
      for (int ra = 0; ra <= int'(r9); ra++) begin
        string t = "";
        if (row == 0 && ra == 1) begin
          sa = sa_mid;
          if (var_sel != 3'd1 && var_sel != 3'd2) t = "R9";
        end
        step(1'b1, (row == 0 && ra == 0), 1'b1, 40, ra, row, row == rows - 1, t);
        for (int h = 0; h <= int'(r1) + 1; h++) begin
          step(1'b0, 1'b0, 1'b1, h, ra, row, row == rows - 1, "");
          if (h == 2) step(1'b0, 1'b0, 1'b0, h, ra, row, row == rows - 1, "R4");
        end
      end
    end
  endtask

  initial begin
    #(5.0 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [13:0] sa_list [5];
    sa_list[0] = 14'h33FE;
    sa_list[1] = 14'h0FFD;
    sa_list[2] = 14'h3FFC;
    sa_list[3] = 14'h1234;
    sa_list[4] = 14'h23FD;
    rst_n = 1'b0; ce = 1'b0; ls = 1'b0; fs = 1'b0; last = 1'b0;
    hcc = '0; vlc = '0; vcc = '0; sa = 14'h1555; r1 = 8'd5; r9 = 5'd1; var_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1", 32'(ma_o), 32'h0);
    chk("R1", 32'(addr_o), 32'h0);
    rst_n = 1'b1;
    for (int v = 0; v < 7; v++) begin
      if (v == 5) continue;
      var_sel = v[2:0];
      for (int f = 0; f < 3; f++) begin
        logic [13:0] s = sa_list[(v + f) % 5];
        run_frame(s, s ^ 14'h0155);
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule